// File: doc/BRIEF.md
# I2C Master Command Register Front End

This block is the register set that a host uses to drive an I2C master. The host reaches it through a simple synchronous register bus with a one-cycle write strobe and a combinational read path. It holds a 16-bit clock divider split over two byte registers, a transmit data register, a receive data register, a control register and a status register. Writing command bits into the control register issues START, byte-write, byte-read and STOP actions to a byte engine. The byte engine does the wire-level signalling and is not part of this block.

The block and the engine talk through level command outputs and single-cycle completion pulses. A command bit stays set until the engine reports the matching action: START generated, byte finished, or STOP generated. When the last outstanding command bit clears, the block records a pending interrupt. That interrupt drives the interrupt output only while the enable bit is set. The host clears it by writing a 1 to the acknowledge bit. The registers are usable straight out of reset.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset the control, status, transmit-data and receive-data registers read 0x00, the command outputs and the interrupt output are low, and the divider registers read the parameter reset value (default 100: low byte 0x64, high byte 0x00).
- R2: Address 0 holds divider bits 7:0 and address 1 holds bits 15:8. A write to either address updates the matching byte of `clk_div_o`, and the same byte reads back from that address.
- R3: Control register (address 2) bits: 0 is reserved and reads 0, 1 is interrupt enable, 2 is interrupt acknowledge and always reads 0, 3 is write-byte, 4 is read-byte, 5 is stop, 6 is start, 7 is the NACK level driven after a received byte. Status register (address 3) bits: 0 is busy (any command bit set), 1 is the captured acknowledge, 2 is interrupt pending. Bits 7:3 of status read 0.
- R4: Writing address 4 changes only the transmit-data register. `tx_byte_o` takes the value of that register only when a control write is accepted with the write-byte bit set.
- R5: The start bit clears one cycle after `eng_start_done`. The write-byte bit clears one cycle after `eng_byte_done`, and at that point status bit 1 takes `eng_rx_ack` (1 = no acknowledge).
- R6: The read-byte bit clears one cycle after `eng_byte_done`, and at that point `eng_rx_byte` is copied into the receive-data register (address 5). A read byte leaves status bit 1 unchanged.
- R7: If stop is set together with write-byte or read-byte, it stays set after the byte completes. It clears only on `eng_stop_done`, and no interrupt is pending before then.
- R8: When a completion pulse clears the last command bit, the interrupt becomes pending (status bit 2). `irq_o` is high exactly when an interrupt is pending and the enable bit is set.
- R9: A control write with bit 2 set clears a pending interrupt. If an operation completes in the same cycle, the interrupt stays pending.
- R10: A control write while busy leaves the command bits unchanged but still updates the interrupt enable bit and the NACK bit.
- R11: A control write with only stop set issues a stand-alone STOP. Its `eng_stop_done` completion raises a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read access |
| irq_o | output | 1 | Level interrupt |
| clk_div_o | output | 16 | Clock divider to the engine |
| tx_byte_o | output | 8 | Byte loaded for the engine's shift register |
| cmd_start_o | output | 1 | START requested |
| cmd_wr_o | output | 1 | Byte write requested |
| cmd_rd_o | output | 1 | Byte read requested |
| cmd_stop_o | output | 1 | STOP requested |
| cmd_nack_o | output | 1 | Send NACK after the received byte |
| eng_start_done | input | 1 | Pulse: START condition generated |
| eng_byte_done | input | 1 | Pulse: byte and its acknowledge bit finished |
| eng_stop_done | input | 1 | Pulse: STOP condition generated |
| eng_rx_ack | input | 1 | Acknowledge sampled after a written byte (1 = none) |
| eng_rx_byte | input | 8 | Byte received by the engine |

## Verification
The host's interrupt acknowledge and the engine's completion of an operation can fall in the same clock cycle. They act on the same pending flag in opposite directions. The bench provokes this by asserting `eng_stop_done` in the same cycle as a control write with the acknowledge bit set. The correct result is that the pending flag survives, so status bit 2 reads 1 afterwards and `irq_o` is high. A second collision is also exercised: a control write while a command is still outstanding, where the command bits must hold while enable and NACK follow the write.

// File: rtl/i2c_hreg_pkg.sv
package i2c_hreg_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CLK0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd5;

  localparam int unsigned CB_IEN   = 1;
  localparam int unsigned CB_IACK  = 2;
  localparam int unsigned CB_WR    = 3;
  localparam int unsigned CB_RD    = 4;
  localparam int unsigned CB_STOP  = 5;
  localparam int unsigned CB_START = 6;
  localparam int unsigned CB_NACK  = 7;

  typedef struct packed {
    logic start;
    logic stop;
    logic rd;
    logic wr;
  } cmd_t;
endpackage

// File: rtl/i2c_hreg_cmd.sv
module i2c_hreg_cmd
  import i2c_hreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] wdata,
  input  logic       start_done,
  input  logic       byte_done,
  input  logic       stop_done,
  output cmd_t       cmd_q,
  output logic       ien_q,
  output logic       nack_q,
  output logic       irq_pend_q,
  output logic       busy,
  output logic       load_tx,
  output logic       wr_fin,
  output logic       rd_fin
);
  cmd_t cmd_d;
  logic accept, cmd_en, finish, pend_en, pend_d;
  logic unused_wdata0;

  assign unused_wdata0 = wdata[0];

  always_comb begin
    busy   = |cmd_q;
    accept = ctrl_we & ~busy;
    cmd_d  = cmd_q;
    if (start_done) cmd_d.start = 1'b0;
    if (byte_done) begin
      cmd_d.wr = 1'b0;
      cmd_d.rd = 1'b0;
    end
    if (stop_done) cmd_d.stop = 1'b0;
    if (accept) begin
      cmd_d.start = wdata[CB_START];
      cmd_d.stop  = wdata[CB_STOP];
      cmd_d.rd    = wdata[CB_RD];
      cmd_d.wr    = wdata[CB_WR];
    end
    cmd_en  = accept | start_done | byte_done | stop_done;
    finish  = busy & (cmd_d == '0);
    pend_en = finish | (ctrl_we & wdata[CB_IACK]);
    pend_d  = finish;
    load_tx = accept & wdata[CB_WR];
    wr_fin  = byte_done & cmd_q.wr;
    rd_fin  = byte_done & cmd_q.rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      ien_q      <= 1'b0;
      nack_q     <= 1'b0;
      irq_pend_q <= 1'b0;
    end else begin
      if (cmd_en) cmd_q <= cmd_d;
      if (ctrl_we) begin
        ien_q  <= wdata[CB_IEN];
        nack_q <= wdata[CB_NACK];
      end
      if (pend_en) irq_pend_q <= pend_d;
    end
  end

  // R5: start drops after the engine reports the START
  p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_done && cmd_q.start) |=> !cmd_q.start);

  // R10: command bits hold when written while busy
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_we && !start_done && !byte_done && !stop_done) |=> $stable(cmd_q));

  // R7: a queued stop survives the byte completion
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cmd_q.stop && !stop_done) |=> (cmd_q.stop && !$rose(irq_pend_q)));

  // R8: an interrupt only becomes pending out of a busy state
  p_pend_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend_q) |-> $past(busy));

  // R9: acknowledge clears the pending flag when nothing completes
  p_iack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[CB_IACK] && !start_done && !byte_done && !stop_done) |=> !irq_pend_q);
endmodule

// File: rtl/i2c_hreg_data.sv
module i2c_hreg_data
  import i2c_hreg_pkg::*;
#(
  parameter int unsigned        DIV_W     = 16,
  parameter logic [DIV_W-1:0]   DIV_RESET = 16'd100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              load_tx,
  input  logic              wr_fin,
  input  logic              rd_fin,
  input  logic              rx_ack,
  input  logic [7:0]        rx_byte,
  output logic [DIV_W-1:0]  clk_div,
  output logic [7:0]        tx_byte,
  output logic [7:0]        txd_q,
  output logic [7:0]        rxd_q,
  output logic              rxack_q
);
  localparam int unsigned DIV_BYTES = DIV_W / 8;

  for (genvar gi = 0; gi < DIV_BYTES; gi++) begin : g_div
    logic       hit;
    logic [7:0] q;
    assign hit = bus_we && (addr == ADDR_W'(int'(A_CLK0) + gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= DIV_RESET[8*gi +: 8];
      else if (hit) q <= wdata;
    end
    assign clk_div[8*gi +: 8] = q;
  end

  logic txd_en;
  assign txd_en = bus_we && (addr == A_TXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= '0;
      tx_byte <= '0;
      rxd_q   <= '0;
      rxack_q <= 1'b0;
    end else begin
      if (txd_en)  txd_q   <= wdata;
      if (load_tx) tx_byte <= txd_q;
      if (rd_fin)  rxd_q   <= rx_byte;
      if (wr_fin)  rxack_q <= rx_ack;
    end
  end

  // R6: the received byte lands in the read register
  p_rx_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fin |=> (rxd_q == $past(rx_byte)));

  // R4: the engine byte moves only on an accepted write command
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_tx |=> $stable(tx_byte));

  // R5: acknowledge status moves only on a finished write byte
  p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fin |=> $stable(rxack_q));
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_hreg_pkg::*;
#(
  parameter int unsigned      DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_o,
  output logic [DIV_W-1:0]  clk_div_o,
  output logic [7:0]        tx_byte_o,
  output logic              cmd_start_o,
  output logic              cmd_wr_o,
  output logic              cmd_rd_o,
  output logic              cmd_stop_o,
  output logic              cmd_nack_o,
  input  logic              eng_start_done,
  input  logic              eng_byte_done,
  input  logic              eng_stop_done,
  input  logic              eng_rx_ack,
  input  logic [7:0]        eng_rx_byte
);
  localparam int unsigned DIV_BYTES = DIV_W / 8;

  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic bus_we, bus_re, ctrl_we;
  assign bus_we  = bus_sel & bus_wr;
  assign bus_re  = bus_sel & ~bus_wr;
  assign ctrl_we = bus_we & (bus_addr == A_CTRL);

  cmd_t       cmd_q;
  logic       ien_q, nack_q, irq_pend_q, busy, load_tx, wr_fin, rd_fin;
  logic [7:0] txd_q, rxd_q;
  logic       rxack_q;

  i2c_hreg_cmd u_cmd (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ctrl_we    (ctrl_we),
    .wdata      (bus_wdata),
    .start_done (eng_start_done),
    .byte_done  (eng_byte_done),
    .stop_done  (eng_stop_done),
    .cmd_q      (cmd_q),
    .ien_q      (ien_q),
    .nack_q     (nack_q),
    .irq_pend_q (irq_pend_q),
    .busy       (busy),
    .load_tx    (load_tx),
    .wr_fin     (wr_fin),
    .rd_fin     (rd_fin)
  );

  i2c_hreg_data #(
    .DIV_W     (DIV_W),
    .DIV_RESET (DIV_RESET)
  ) u_data (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .bus_we  (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .load_tx (load_tx),
    .wr_fin  (wr_fin),
    .rd_fin  (rd_fin),
    .rx_ack  (eng_rx_ack),
    .rx_byte (eng_rx_byte),
    .clk_div (clk_div_o),
    .tx_byte (tx_byte_o),
    .txd_q   (txd_q),
    .rxd_q   (rxd_q),
    .rxack_q (rxack_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      for (int i = 0; i < DIV_BYTES; i++) begin
        if (bus_addr == ADDR_W'(int'(A_CLK0) + i)) bus_rdata = clk_div_o[8*i +: 8];
      end
      case (bus_addr)
        A_CTRL:  bus_rdata = {nack_q, cmd_q.start, cmd_q.stop, cmd_q.rd,
                              cmd_q.wr, 1'b0, ien_q, 1'b0};
        A_STAT:  bus_rdata = {5'b0, irq_pend_q, rxack_q, busy};
        A_TXD:   bus_rdata = txd_q;
        A_RXD:   bus_rdata = rxd_q;
        default: ;
      endcase
    end
  end

  assign irq_o       = irq_pend_q & ien_q;
  assign cmd_start_o = cmd_q.start;
  assign cmd_wr_o    = cmd_q.wr;
  assign cmd_rd_o    = cmd_q.rd;
  assign cmd_stop_o  = cmd_q.stop;
  assign cmd_nack_o  = nack_q;
endmodule

// File: tb/tb_i2c_host_regs.sv
`timescale 1ns/1ps
module tb_i2c_host_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        irq_o;
  logic [15:0] clk_div_o;
  logic [7:0]  tx_byte_o;
  logic        cmd_start_o, cmd_wr_o, cmd_rd_o, cmd_stop_o, cmd_nack_o;
  logic        eng_start_done, eng_byte_done, eng_stop_done, eng_rx_ack;
  logic [7:0]  eng_rx_byte;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  i2c_host_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .clk_div_o(clk_div_o), .tx_byte_o(tx_byte_o),
    .cmd_start_o(cmd_start_o), .cmd_wr_o(cmd_wr_o), .cmd_rd_o(cmd_rd_o),
    .cmd_stop_o(cmd_stop_o), .cmd_nack_o(cmd_nack_o),
    .eng_start_done(eng_start_done), .eng_byte_done(eng_byte_done),
    .eng_stop_done(eng_stop_done), .eng_rx_ack(eng_rx_ack),
    .eng_rx_byte(eng_rx_byte)
  );

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (bus_sel === 1'b1 && bus_wr === 1'b0) begin
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read addr %0d got %02h expected none", bus_addr, bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s addr %0d got %02h expected %02h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: eng_start_done = 1'b1;
      1: eng_byte_done  = 1'b1;
      default: eng_stop_done = 1'b1;
    endcase
    @(negedge clk);
    eng_start_done = 1'b0; eng_byte_done = 1'b0; eng_stop_done = 1'b0;
  endtask

  task automatic check_pin(input logic [15:0] got, input logic [15:0] e, input string t);
    #1;
    n_cmp++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s pin got %04h expected %04h", t, got, e);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired got hang expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_start_done = 1'b0; eng_byte_done = 1'b0; eng_stop_done = 1'b0;
    eng_rx_ack = 1'b0; eng_rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(3'd0, 8'h64, "R1 div low");
    bus_read(3'd1, 8'h00, "R1 div high");
    bus_read(3'd2, 8'h00, "R1 ctrl");
    bus_read(3'd3, 8'h00, "R1 status");
    bus_read(3'd5, 8'h00, "R1 rxdata");
    check_pin({15'd0, irq_o}, 16'd0, "R1 irq");
    check_pin({11'd0, cmd_start_o, cmd_wr_o, cmd_rd_o, cmd_stop_o, cmd_nack_o}, 16'd0, "R1 cmds");

    // R2 divider bytes
    bus_write(3'd0, 8'h34);
    bus_write(3'd1, 8'h12);
    check_pin(clk_div_o, 16'h1234, "R2 clk_div");
    bus_read(3'd0, 8'h34, "R2 div low");
    bus_read(3'd1, 8'h12, "R2 div high");

    // R4 data register alone does not load the engine byte
    bus_write(3'd4, 8'hA4);
    bus_read(3'd4, 8'hA4, "R4 txdata");
    check_pin({8'd0, tx_byte_o}, 16'h0000, "R4 no load");
    // R3 start+write+ien
    bus_write(3'd2, 8'h4A);
    bus_read(3'd2, 8'h4A, "R3 ctrl readback");
    bus_read(3'd3, 8'h01, "R3 busy");
    check_pin({8'd0, tx_byte_o}, 16'h00A4, "R4 loaded");
    check_pin({12'd0, cmd_start_o, cmd_wr_o, cmd_rd_o, cmd_stop_o}, 16'b1100, "R4 cmds");

    // R10 write while busy
    bus_write(3'd4, 8'h55);
    bus_write(3'd2, 8'h92);
    bus_read(3'd2, 8'hCA, "R10 ctrl");
    check_pin({8'd0, tx_byte_o}, 16'h00A4, "R10 tx hold");
    check_pin({15'd0, cmd_nack_o}, 16'd1, "R10 nack");

    // R5 start done then byte done with no ack
    pulse(0);
    bus_read(3'd2, 8'h8A, "R5 start cleared");
    bus_read(3'd3, 8'h01, "R5 still busy");
    check_pin({15'd0, irq_o}, 16'd0, "R5 no irq yet");
    eng_rx_ack = 1'b1;
    pulse(1);
    bus_read(3'd2, 8'h82, "R5 wr cleared");
    bus_read(3'd3, 8'h06, "R8 pending rxack");
    check_pin({15'd0, irq_o}, 16'd1, "R8 irq");

    // R9 acknowledge
    bus_write(3'd2, 8'h06);
    bus_read(3'd2, 8'h02, "R3 iack reads 0");
    bus_read(3'd3, 8'h02, "R9 cleared");
    check_pin({15'd0, irq_o}, 16'd0, "R9 irq low");

    // R6 read byte with nack
    eng_rx_byte = 8'h3C; eng_rx_ack = 1'b0;
    bus_write(3'd2, 8'h92);
    check_pin({13'd0, cmd_rd_o, cmd_wr_o, cmd_nack_o}, 16'b101, "R6 rd cmd");
    bus_read(3'd3, 8'h03, "R6 busy");
    pulse(1);
    bus_read(3'd5, 8'h3C, "R6 rxdata");
    bus_read(3'd3, 8'h06, "R6 rxack kept");
    bus_read(3'd2, 8'h82, "R6 rd cleared");
    check_pin({15'd0, irq_o}, 16'd1, "R6 irq");

    // R7 write with stop
    bus_write(3'd2, 8'h06);
    bus_write(3'd2, 8'h2A);
    check_pin({8'd0, tx_byte_o}, 16'h0055, "R4 second load");
    pulse(1);
    bus_read(3'd2, 8'h22, "R7 stop held");
    bus_read(3'd3, 8'h01, "R7 no pending");
    check_pin({15'd0, irq_o}, 16'd0, "R7 irq low");

    // R9 completion and acknowledge in one cycle
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h06;
    eng_stop_done = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; eng_stop_done = 1'b0;
    bus_read(3'd3, 8'h04, "R9 completion wins");
    bus_read(3'd2, 8'h02, "R9 ctrl");
    check_pin({15'd0, irq_o}, 16'd1, "R9 irq high");

    // R11 stand-alone stop
    bus_write(3'd2, 8'h06);
    bus_write(3'd2, 8'h22);
    check_pin({15'd0, cmd_stop_o}, 16'd1, "R11 stop cmd");
    bus_read(3'd3, 8'h01, "R11 busy");
    pulse(2);
    bus_read(3'd3, 8'h04, "R11 pending");
    check_pin({15'd0, irq_o}, 16'd1, "R11 irq");

    // R8 enable gates the output
    bus_write(3'd2, 8'h04);
    bus_read(3'd3, 8'h00, "R8 cleared");
    bus_write(3'd2, 8'h20);
    pulse(2);
    bus_read(3'd3, 8'h04, "R8 pending masked");
    check_pin({15'd0, irq_o}, 16'd0, "R8 irq masked");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard got %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule